// File: doc/BRIEF.md
# Boot Sector Write-Protection Controller

This block sits between a flash command decoder and the array's program/erase engine. For every request it receives a word address and an operation code. It returns the erase sector the address falls in, whether the operation may proceed, and a per-sector mask of what an erase would actually clear. The word space holds four erase sectors: a boot sector of `BOOT_WORDS`, two parameter sectors of `PARAM_WORDS` each, and a main sector that covers the rest. A parameter selects whether the boot sector sits at the bottom or at the top of the space.

A sticky lock flag protects the boot sector. Software sets it with a fixed six-write key sequence on a separate command port. Once set, the flag survives the functional reset and is cleared only by the power-on reset. While the flag is set, program and sector-erase requests aimed at the boot sector are refused. A chip erase still goes ahead but leaves the boot sector out of its mask. A high-voltage override input lifts the protection for as long as it is held. In identification mode, a read of the word two above the boot sector's base returns the lock flag on bit 0.

Top module: `boot_guard`

## Requirements
- R1: With bottom placement the sector code (0 boot, 1 parameter one, 2 parameter two, 3 main) is 0 for addresses below BOOT_WORDS, 1 for the next PARAM_WORDS, 2 for the PARAM_WORDS after that, and 3 above. The code is a combinational function of the address.
- R2: With top placement the boot sector is the highest BOOT_WORDS addresses, parameter one the PARAM_WORDS just below it, parameter two the PARAM_WORDS below that, and main everything underneath.
- R3: With the lock set and the override low, a program (op 1) or sector erase (op 2) whose address decodes to the boot sector gives allow = 0. The same operations to any other sector give allow = 1, and reads (op 0) always give allow = 1.
- R4: With the lock clear, allow is 1 for every address and operation.
- R5: A chip erase (op 3) always gives allow = 1 and an erase mask with bits 3..1 set. Bit 0 (boot) is set unless the lock is set and the override is low.
- R6: A sector erase that is allowed sets exactly the mask bit of the addressed sector. A denied sector erase, a read or a program gives mask 0.
- R7: While hv_override is high, boot-sector program and sector erase are allowed under a set lock. Once it drops, the refusal returns at once.
- R8: With id_mode high and the address equal to the boot sector base plus 2, id_status is 8'h01 when locked and 8'h00 when not. At any other address, or with id_mode low, it is 8'h00.
- R9: The lock sets on the clock edge that takes the sixth correct write of the sequence (low address bits 0x55/0xAA/0x55/0x55/0xAA/0x55 with data 0xAA/0x55/0x80/0xAA/0x55/0x40). A wrong write breaks the sequence, and a wrong sixth write leaves the lock clear.
- R10: rst_n low clears the sequence progress but not the lock. por_n low clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, synchronous, active low; lock kept |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears lock |
| addr | input | ADDR_W | Word address of the request |
| op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| hv_override | input | 1 | High-voltage override level, lifts protection while high |
| id_mode | input | 1 | Identification space is being read |
| cmd_we | input | 1 | Command write strobe |
| cmd_addr | input | ADDR_W | Command write address |
| cmd_data | input | 8 | Command write data |
| sector | output | 2 | Sector code of addr |
| allow | output | 1 | Request may proceed |
| erase_mask | output | 4 | Sectors an erase would clear, bit i for sector code i |
| id_status | output | 8 | Lock status on bit 0 at the identification address |

## Verification
A lock flag that is wrongly set or wrongly cleared shows in two places during the same cycle. One is the identification read at boot base plus 2. The other is allow for a boot program, together with mask bit 0 for a chip erase. A sequence counter that fails to track progress shows one edge after the sixth write, as a lock that is missing or set too early. A boundary placed one word off shows up as a wrong sector code at exactly one address, so every address of both placements is swept with the lock clear, set, and overridden.

// File: rtl/bg_pkg.sv
// Shared types and the lock key sequence for the boot-sector guard.
// Assumes command addresses fit in 20 bits; wider address spaces compare low bits.
package bg_pkg;

    typedef enum logic [1:0] {
        SEC_BOOT   = 2'd0,
        SEC_PARAM1 = 2'd1,
        SEC_PARAM2 = 2'd2,
        SEC_MAIN   = 2'd3
    } sector_e;

    typedef enum logic [1:0] {
        OP_READ        = 2'd0,
        OP_PROGRAM     = 2'd1,
        OP_SECTOR_ERASE = 2'd2,
        OP_CHIP_ERASE  = 2'd3
    } op_e;

    localparam int          KEY_LEN    = 6;
    localparam logic [19:0] KEY_ADDR_A = 20'h05555;
    localparam logic [19:0] KEY_ADDR_B = 20'h02AAA;

    // Address expected at a given step of the key sequence.
    function automatic logic [19:0] key_addr(input int step);
        return (step == 1 || step == 4) ? KEY_ADDR_B : KEY_ADDR_A;
    endfunction

    // Data byte expected at a given step of the key sequence.
    function automatic logic [7:0] key_data(input int step);
        case (step)
            0: return 8'hAA;
            1: return 8'h55;
            2: return 8'h80;
            3: return 8'hAA;
            4: return 8'h55;
            default: return 8'h40;
        endcase
    endfunction

endpackage

// File: rtl/bg_sector_decode.sv
// Maps a word address onto one of four erase sectors and gives the
// identification address (boot base + ID_OFFSET). Purely combinational.
// Assumes BOOT_WORDS + 2*PARAM_WORDS < 2**ADDR_W.
module bg_sector_decode #(
    parameter int ADDR_W      = 19,
    parameter int BOOT_WORDS  = 8192,
    parameter int PARAM_WORDS = 4096,
    parameter bit TOP_BOOT    = 1'b0,
    parameter int ID_OFFSET   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        sector,
    output logic              is_boot,
    output logic [ADDR_W-1:0] id_addr
);
    import bg_pkg::*;

    localparam int DEPTH = 2 ** ADDR_W;

    logic [ADDR_W:0] a_ext;
    sector_e         sec;

    assign a_ext = {1'b0, addr};

    generate
        if (TOP_BOOT) begin : g_top
            localparam int BOOT_LO = DEPTH - BOOT_WORDS;
            localparam int P1_LO   = BOOT_LO - PARAM_WORDS;
            localparam int P2_LO   = P1_LO - PARAM_WORDS;
            localparam logic [ADDR_W:0] L_BOOT = (ADDR_W+1)'(BOOT_LO);
            localparam logic [ADDR_W:0] L_P1   = (ADDR_W+1)'(P1_LO);
            localparam logic [ADDR_W:0] L_P2   = (ADDR_W+1)'(P2_LO);
            localparam logic [ADDR_W:0] L_ID   = (ADDR_W+1)'(BOOT_LO + ID_OFFSET);
            // Compare against descending lower bounds, boot at the top.
            always_comb begin
                if (a_ext >= L_BOOT)    sec = SEC_BOOT;
                else if (a_ext >= L_P1) sec = SEC_PARAM1;
                else if (a_ext >= L_P2) sec = SEC_PARAM2;
                else                    sec = SEC_MAIN;
            end
            assign id_addr = L_ID[ADDR_W-1:0];
        end else begin : g_bottom
            localparam logic [ADDR_W:0] L_P1   = (ADDR_W+1)'(BOOT_WORDS);
            localparam logic [ADDR_W:0] L_P2   = (ADDR_W+1)'(BOOT_WORDS + PARAM_WORDS);
            localparam logic [ADDR_W:0] L_MAIN = (ADDR_W+1)'(BOOT_WORDS + 2 * PARAM_WORDS);
            localparam logic [ADDR_W:0] L_ID   = (ADDR_W+1)'(ID_OFFSET);
            // Compare against ascending upper bounds, boot at the bottom.
            always_comb begin
                if (a_ext < L_P1)        sec = SEC_BOOT;
                else if (a_ext < L_P2)   sec = SEC_PARAM1;
                else if (a_ext < L_MAIN) sec = SEC_PARAM2;
                else                     sec = SEC_MAIN;
            end
            assign id_addr = L_ID[ADDR_W-1:0];
        end
    endgenerate

    assign sector  = sec;
    assign is_boot = (sec == SEC_BOOT);

endmodule

// File: rtl/bg_lock_seq.sv
// Tracks the six-write key sequence on the command port and holds the
// sticky lock flag. Progress clears on either reset; the flag only on por_n.
// Assumes one command write per strobe cycle.
module bg_lock_seq #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              lock_q
);
    import bg_pkg::*;

    localparam int STEP_W = $clog2(KEY_LEN + 1);

    logic [KEY_LEN-1:0] hit;
    logic [STEP_W-1:0]  step_q;
    logic               cur_hit;
    logic               last_hit;

    // One comparator per key step.
    generate
        for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
            localparam logic [19:0] KA = key_addr(g);
            localparam logic [7:0]  KD = key_data(g);
            assign hit[g] = cmd_we && (cmd_addr == KA[ADDR_W-1:0]) && (cmd_data == KD);
        end
    endgenerate

    assign cur_hit  = hit[step_q];
    assign last_hit = cur_hit && (step_q == STEP_W'(KEY_LEN - 1));

    // Advance on a matching write, restart on a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            step_q <= '0;
        end else if (cmd_we) begin
            if (last_hit)     step_q <= '0;
            else if (cur_hit) step_q <= step_q + 1'b1;
            else if (hit[0])  step_q <= STEP_W'(1);
            else              step_q <= '0;
        end
    end

    // Sticky lock flag, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lock_q <= 1'b0;
        end else if (rst_n && last_hit) begin
            lock_q <= 1'b1;
        end
    end

endmodule

// File: rtl/bg_access_gate.sv
// Decides allow/deny, forms the erase mask and drives the identification
// status from the decoded sector, lock flag and override level.
// Combinational; assumes sector and is_boot come from the same address.
module bg_access_gate #(
    parameter int ADDR_W    = 19,
    parameter int N_SECTORS = 4
) (
    input  logic [1:0]           op,
    input  logic [1:0]           sector,
    input  logic                 is_boot,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ADDR_W-1:0]    id_addr,
    input  logic                 lock_q,
    input  logic                 hv_override,
    input  logic                 id_mode,
    output logic                 allow,
    output logic [N_SECTORS-1:0] erase_mask,
    output logic [7:0]           id_status
);
    import bg_pkg::*;

    op_e  op_i;
    logic protect;
    logic writes;
    logic deny;

    assign op_i    = op_e'(op);
    assign protect = lock_q && !hv_override;
    assign writes  = (op_i == OP_PROGRAM) || (op_i == OP_SECTOR_ERASE);
    assign deny    = protect && is_boot && writes;
    assign allow   = !deny;

    // One mask bit per sector; sector code 0 is the boot sector.
    generate
        for (genvar s = 0; s < N_SECTORS; s++) begin : g_mask
            logic kept;
            assign kept = (s == 0) ? protect : 1'b0;
            always_comb begin
                case (op_i)
                    OP_CHIP_ERASE:   erase_mask[s] = !kept;
                    OP_SECTOR_ERASE: erase_mask[s] = !deny && (sector == 2'(s));
                    default:         erase_mask[s] = 1'b0;
                endcase
            end
        end
    endgenerate

    // Lock status appears only at the identification address.
    assign id_status = (id_mode && addr == id_addr) ? {7'b0, lock_q} : 8'h00;

endmodule

// File: rtl/boot_guard.sv
// Top of the boot-sector write-protection controller. Decodes the request
// address, applies the sticky lock with its override, and reports the lock in
// identification mode. Assumes the caller holds hv_override for a whole operation.
module boot_guard #(
    parameter int ADDR_W      = 19,
    parameter int BOOT_WORDS  = 8192,
    parameter int PARAM_WORDS = 4096,
    parameter bit TOP_BOOT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic              hv_override,
    input  logic              id_mode,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic [1:0]        sector,
    output logic              allow,
    output logic [3:0]        erase_mask,
    output logic [7:0]        id_status
);
    logic              is_boot;
    logic [ADDR_W-1:0] id_addr;
    logic              lock_q;

    bg_sector_decode #(
        .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS),
        .TOP_BOOT(TOP_BOOT), .ID_OFFSET(2)
    ) u_dec (
        .addr(addr), .sector(sector), .is_boot(is_boot), .id_addr(id_addr)
    );

    bg_lock_seq #(.ADDR_W(ADDR_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock_q(lock_q)
    );

    bg_access_gate #(.ADDR_W(ADDR_W), .N_SECTORS(4)) u_gate (
        .op(op), .sector(sector), .is_boot(is_boot), .addr(addr),
        .id_addr(id_addr), .lock_q(lock_q), .hv_override(hv_override),
        .id_mode(id_mode), .allow(allow), .erase_mask(erase_mask),
        .id_status(id_status)
    );

endmodule

// File: rtl/bg_guard_chk.sv
// Property checker for boot_guard, attached with bind below.
module bg_guard_chk (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] op,
    input logic [1:0] sector,
    input logic       allow,
    input logic [3:0] erase_mask,
    input logic       hv_override,
    input logic       cmd_we,
    input logic       lock_q
);
    // R3
    boot_write_denied_chk: assert property (@(posedge clk) disable iff (!por_n)
        (lock_q && !hv_override && sector == 2'd0 && (op == 2'd1 || op == 2'd2)) |-> !allow);

    // R4
    open_when_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !lock_q |-> allow);

    // R5
    chip_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op == 2'd3) |-> (allow && erase_mask[3:1] == 3'b111
                          && erase_mask[0] == !(lock_q && !hv_override)));

    // R6
    single_sector_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op != 2'd3) |-> ($onehot0(erase_mask) && (op == 2'd2 || erase_mask == 4'b0)));

    // R7
    override_open_chk: assert property (@(posedge clk) disable iff (!por_n)
        hv_override |-> allow);

    // R9
    lock_by_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(lock_q) |-> $past(cmd_we));

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q);

endmodule

bind boot_guard bg_guard_chk u_chk (.*);

// File: tb/tb_boot_guard.sv
`timescale 1ns/1ps
module tb_boot_guard;
    localparam int AW = 8;
    localparam int BW = 32;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0;
    logic [AW-1:0] addr = '0, cmd_addr = '0;
    logic [1:0] op = 2'd0;
    logic hv_override = 1'b0, id_mode = 1'b0, cmd_we = 1'b0;
    logic [7:0] cmd_data = 8'h00;

    logic [1:0] sec_b, sec_t;
    logic allow_b, allow_t;
    logic [3:0] mask_b, mask_t;
    logic [7:0] id_b, id_t;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    boot_guard #(.ADDR_W(AW), .BOOT_WORDS(BW), .PARAM_WORDS(PW), .TOP_BOOT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .op(op),
        .hv_override(hv_override), .id_mode(id_mode), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sector(sec_b), .allow(allow_b),
        .erase_mask(mask_b), .id_status(id_b));

    boot_guard #(.ADDR_W(AW), .BOOT_WORDS(BW), .PARAM_WORDS(PW), .TOP_BOOT(1'b1)) dut_top (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .op(op),
        .hv_override(hv_override), .id_mode(id_mode), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sector(sec_t), .allow(allow_t),
        .erase_mask(mask_t), .id_status(id_t));

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (addr=%0d op=%0d)", req, got, exp, addr, op);
        end
    endtask

    function automatic logic [1:0] exp_sec(input int a, input bit top);
        if (!top) return (a < BW) ? 2'd0 : (a < BW + PW) ? 2'd1 : (a < BW + 2 * PW) ? 2'd2 : 2'd3;
        return (a >= 256 - BW) ? 2'd0 : (a >= 256 - BW - PW) ? 2'd1
             : (a >= 256 - BW - 2 * PW) ? 2'd2 : 2'd3;
    endfunction

    task automatic check_point(input bit top, input int a, input int o, input bit lk, input bit hv);
        logic [1:0] s;
        logic prot, deny;
        logic [3:0] m;
        int base;
        string areq;
        s    = exp_sec(a, top);
        prot = lk && !hv;
        deny = prot && s == 2'd0 && (o == 1 || o == 2);
        if (o == 3)      m = prot ? 4'b1110 : 4'b1111;
        else if (o == 2) m = deny ? 4'b0000 : (4'b0001 << s);
        else             m = 4'b0000;
        base = top ? 256 - BW : 0;
        areq = hv ? "R7" : (lk ? "R3" : "R4");
        if (top) begin
            chk("R2 sector", {6'b0, sec_t}, {6'b0, s});
            chk(areq, {7'b0, allow_t}, {7'b0, !deny});
            chk(o == 3 ? "R5" : "R6", {4'b0, mask_t}, {4'b0, m});
            chk("R8", id_t, (a == base + 2) ? {7'b0, lk} : 8'h00);
        end else begin
            chk("R1 sector", {6'b0, sec_b}, {6'b0, s});
            chk(areq, {7'b0, allow_b}, {7'b0, !deny});
            chk(o == 3 ? "R5" : "R6", {4'b0, mask_b}, {4'b0, m});
            chk("R8", id_b, (a == base + 2) ? {7'b0, lk} : 8'h00);
        end
    endtask

    task automatic sweep(input bit lk, input bit hv);
        for (int a = 0; a < 256; a++) begin
            for (int o = 0; o < 4; o++) begin
                @(negedge clk);
                addr = AW'(a); op = 2'(o); hv_override = hv; id_mode = 1'b1;
                #1;
                check_point(1'b0, a, o, lk, hv);
                check_point(1'b1, a, o, lk, hv);
            end
        end
        hv_override = 1'b0;
    endtask

    task automatic id_check(input logic lk, input string req);
        @(negedge clk);
        op = 2'd0; id_mode = 1'b1; addr = AW'(2);
        #1 chk(req, id_b, {7'b0, lk});
        addr = AW'(256 - BW + 2);
        #1 chk(req, id_t, {7'b0, lk});
    endtask

    task automatic cmd(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic key_first5();
        cmd(8'h55, 8'hAA); cmd(8'hAA, 8'h55); cmd(8'h55, 8'h80);
        cmd(8'h55, 8'hAA); cmd(8'hAA, 8'h55);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        // R10: power-on state is unlocked
        id_check(1'b0, "R10 reset");
        // R8: id_mode low hides status
        @(negedge clk); id_mode = 1'b0; addr = AW'(2);
        #1 chk("R8 id_mode low", id_b, 8'h00);
        // R1 R2 R4 R5 R6 R8 unlocked sweep
        sweep(1'b0, 1'b0);
        // R9: wrong sixth write leaves lock clear
        key_first5(); cmd(8'h55, 8'h41);
        id_check(1'b0, "R9 bad sixth");
        // R10: functional reset between steps clears progress
        key_first5();
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        cmd(8'h55, 8'h40);
        id_check(1'b0, "R10 progress cleared");
        // R9: full sequence sets the lock
        key_first5(); cmd(8'h55, 8'h40);
        id_check(1'b1, "R9 locked");
        // R3 R5 R6 R8 locked sweep
        sweep(1'b1, 1'b0);
        // R7 override sweep, then release
        sweep(1'b1, 1'b1);
        @(negedge clk); hv_override = 1'b0; op = 2'd1; addr = AW'(5);
        #1 chk("R7 released", {7'b0, allow_b}, 8'h00);
        // R10: functional reset keeps lock
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        id_check(1'b1, "R10 rst_n keeps lock");
        // R10: power-on reset clears lock
        @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        id_check(1'b0, "R10 por_n clears lock");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule